// File: doc/BRIEF.md
# Commit-Ordered Trace Signature Checker

This block sits between the decode-signature generator and a signature cache in an out-of-order core. Every fetched trace (a run of instructions closed by a branch or a length limit) produces a signature, and that signature is dispatched into a small in-order queue together with the trace start PC. The queue returns a slot tag to the dispatcher. When a branch turns out mispredicted, the core names the tag of the last correct-path trace, and every younger entry is dropped in the same clock edge. Wrong-path signatures therefore never reach the cache.

The oldest entry drives a lookup into the signature cache, keyed by its start PC. The cache answers in the same cycle once it is ready. On a miss the entry is written into the cache and retires. On a hit with equal signatures it retires. On a hit with different signatures, the outcome depends on a single retry flag kept outside the queue. If the flag is not armed for this PC, the block arms it and asks for a pipeline flush and a refetch from the trace start PC. If the flag is already armed for this PC, the retried trace has failed a second time. The stored reference is then taken to be corrupt, and the block requests an abort or rollback. If a retried trace matches, the block reports a successful recovery and disarms the flag.

Top module: `sig_commit_ctrl`

## Requirements
- R1: After reset the queue is empty. `disp_full`, `lk_valid`, `wr_en`, `flush_req`, `fault_det`, `recovered` and `abort_req` are all low, and the first dispatch receives tag 0.
- R2: Entries leave in dispatch order. `lk_valid` is high whenever the queue holds an entry, and `lk_pc`/`lk_sig` show the oldest one. `disp_tag` gives the slot the current dispatch will take: tags count up from 0 and wrap modulo DEPTH, and the counter restarts at 0 after any mismatch.
- R3: `disp_full` is high exactly when DEPTH entries are held. A dispatch while full is dropped, and the queue never holds more than DEPTH entries.
- R4: With `sq_valid` high, every entry younger than `sq_tag` is removed at the next edge, and the entry with that tag is kept. A dispatch in the same cycle is dropped, and the next dispatch receives tag `sq_tag`+1 modulo DEPTH.
- R5: While `lk_ready` is low, the head entry stays in place and the block writes nothing and reports nothing.
- R6: A miss (`lk_ready`=1, `lk_hit`=0) raises `wr_en` in that cycle, with `wr_pc`/`wr_sig` equal to the head entry, and the entry retires.
- R7: A hit whose `lk_ref_sig` equals the head signature retires the entry. It raises no write, and no pulse follows unless the retry flag is armed for that PC.
- R8: The first mismatch for a PC empties the queue at the edge. In the next cycle `fault_det` and `flush_req` pulse for one cycle, `restart_pc` holds that trace's PC, and the retry flag is armed for that PC.
- R9: A mismatch while the retry flag is armed for the head PC empties the queue. In the next cycle `abort_req` pulses for one cycle without `flush_req`, and the flag is disarmed.
- R10: A matching hit while the retry flag is armed for the head PC pulses `recovered` for one cycle in the next cycle and disarms the flag. A miss on that PC disarms the flag without a pulse.
- R11: The retry flag survives the flush that empties the queue, and commits of other PCs leave it alone. Once disarmed, a later mismatch on the same PC is again a first mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A trace signature is dispatched this cycle |
| disp_pc | input | PC_W | Start PC of the dispatched trace |
| disp_sig | input | SIG_W | Signature of the dispatched trace |
| disp_tag | output | $clog2(DEPTH) | Slot tag that the current dispatch occupies |
| disp_full | output | 1 | Queue full, dispatch must stall |
| sq_valid | input | 1 | Squash everything younger than `sq_tag` |
| sq_tag | input | $clog2(DEPTH) | Tag of the youngest surviving entry |
| lk_valid | output | 1 | Lookup request for the head entry |
| lk_pc | output | PC_W | Lookup key (head start PC) |
| lk_sig | output | SIG_W | Head signature |
| lk_ready | input | 1 | Cache result valid this cycle |
| lk_hit | input | 1 | Cache holds an entry for `lk_pc` |
| lk_ref_sig | input | SIG_W | Stored reference signature |
| wr_en | output | 1 | Write head signature into the cache |
| wr_pc | output | PC_W | Write key |
| wr_sig | output | SIG_W | Write data |
| flush_req | output | 1 | One-cycle pipeline flush request |
| restart_pc | output | PC_W | Refetch address for the flush |
| fault_det | output | 1 | One-cycle pulse: fault detected |
| recovered | output | 1 | One-cycle pulse: retried trace matched |
| abort_req | output | 1 | One-cycle pulse: stored reference corrupt |

## Verification
The queue is first exercised with the lookup held off, so ordering and stalls can be seen apart from commits. Then, with the cache ready, three patterns run in turn: a miss, a matching hit and a mismatching hit. Together they separate the write path, quiet retirement and the first-strike flush. A PC is then replayed after its flush with a bad reference and with a good one. This tells a repeat failure (abort) apart from a transient one (recovery), and the replay is interleaved with an unrelated PC to show the flag survives both the flush and unrelated commits. A filled queue is squashed in the middle while a dispatch is offered, and a long mixed run adds random squashes, stalls and mismatches against a behavioural queue model.

// File: rtl/srq_pkg.sv
package srq_pkg;
    // Outcome of the head entry in one cycle
    typedef enum logic [1:0] {
        VD_NONE   = 2'd0,  // nothing committed
        VD_RETIRE = 2'd1,  // miss or matching hit, entry leaves
        VD_FIRST  = 2'd2,  // first mismatch for this PC
        VD_REPEAT = 2'd3   // mismatch again after retry
    } srq_verdict_e;
endpackage

// File: rtl/srq_fifo.sv
module srq_fifo #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 16,
    parameter int SIG_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PC_W-1:0]  push_pc,
    input  logic [SIG_W-1:0] push_sig,
    input  logic             pop,
    input  logic             clear,
    input  logic             squash,
    input  logic [PTR_W-1:0] squash_tag,
    output logic [PTR_W-1:0] tail_tag,
    output logic             full,
    output logic             head_valid,
    output logic [PC_W-1:0]  head_pc,
    output logic [SIG_W-1:0] head_sig,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [SIG_W-1:0] sig;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0] hd;
        logic [PTR_W-1:0] tl;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [PTR_W-1:0] span;

    always_comb begin
        st_d = st_q;
        span = squash_tag - st_q.hd;
        if (clear) begin
            st_d.hd  = '0;
            st_d.tl  = '0;
            st_d.cnt = '0;
        end else begin
            if (squash) begin
                // keep head..squash_tag inclusive
                st_d.tl  = squash_tag + PTR_W'(1);
                st_d.cnt = CNT_W'(span) + CNT_W'(1);
            end else if (push && !full) begin
                st_d.mem[st_q.tl].pc  = push_pc;
                st_d.mem[st_q.tl].sig = push_sig;
                st_d.tl  = st_q.tl + PTR_W'(1);
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            if (pop) begin
                st_d.hd  = st_q.hd + PTR_W'(1);
                st_d.cnt = st_d.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tail_tag   = st_q.tl;
    assign full       = (st_q.cnt == CNT_W'(DEPTH));
    assign head_valid = (st_q.cnt != '0);
    assign head_pc    = st_q.mem[st_q.hd].pc;
    assign head_sig   = st_q.mem[st_q.hd].sig;
    assign count      = st_q.cnt;
endmodule

// File: rtl/srq_check.sv
module srq_check
    import srq_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int SIG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic [PC_W-1:0]  head_pc,
    input  logic [SIG_W-1:0] head_sig,
    input  logic             cache_ready,
    input  logic             cache_hit,
    input  logic [SIG_W-1:0] cache_sig,
    output logic             pop,
    output logic             clear,
    output logic             wr_en,
    output logic             flush_req,
    output logic [PC_W-1:0]  restart_pc,
    output logic             fault_det,
    output logic             recovered,
    output logic             abort_req
);
    typedef struct packed {
        logic            armed;
        logic [PC_W-1:0] armed_pc;
        logic            flush;
        logic [PC_W-1:0] rst_pc;
        logic            fault;
        logic            rec;
        logic            abort;
    } st_t;

    st_t st_d, st_q;
    srq_verdict_e verdict;
    logic retried;

    always_comb begin
        retried = st_q.armed && (st_q.armed_pc == head_pc);
        verdict = VD_NONE;
        if (head_valid && cache_ready) begin
            if (cache_hit && (cache_sig != head_sig))
                verdict = retried ? VD_REPEAT : VD_FIRST;
            else
                verdict = VD_RETIRE;
        end

        st_d       = st_q;
        st_d.flush = 1'b0;
        st_d.fault = 1'b0;
        st_d.rec   = 1'b0;
        st_d.abort = 1'b0;
        case (verdict)
            VD_FIRST: begin
                st_d.armed    = 1'b1;
                st_d.armed_pc = head_pc;
                st_d.flush    = 1'b1;
                st_d.rst_pc   = head_pc;
                st_d.fault    = 1'b1;
            end
            VD_REPEAT: begin
                st_d.armed = 1'b0;
                st_d.abort = 1'b1;
            end
            VD_RETIRE: begin
                if (retried) begin
                    st_d.armed = 1'b0;
                    st_d.rec   = cache_hit;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop        = (verdict == VD_RETIRE);
    assign clear      = (verdict == VD_FIRST) || (verdict == VD_REPEAT);
    assign wr_en      = (verdict == VD_RETIRE) && !cache_hit;
    assign flush_req  = st_q.flush;
    assign restart_pc = st_q.rst_pc;
    assign fault_det  = st_q.fault;
    assign recovered  = st_q.rec;
    assign abort_req  = st_q.abort;
endmodule

// File: rtl/sig_commit_ctrl.sv
module sig_commit_ctrl #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 16,
    parameter int SIG_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic [PC_W-1:0]  disp_pc,
    input  logic [SIG_W-1:0] disp_sig,
    output logic [PTR_W-1:0] disp_tag,
    output logic             disp_full,
    input  logic             sq_valid,
    input  logic [PTR_W-1:0] sq_tag,
    output logic             lk_valid,
    output logic [PC_W-1:0]  lk_pc,
    output logic [SIG_W-1:0] lk_sig,
    input  logic             lk_ready,
    input  logic             lk_hit,
    input  logic [SIG_W-1:0] lk_ref_sig,
    output logic             wr_en,
    output logic [PC_W-1:0]  wr_pc,
    output logic [SIG_W-1:0] wr_sig,
    output logic             flush_req,
    output logic [PC_W-1:0]  restart_pc,
    output logic             fault_det,
    output logic             recovered,
    output logic             abort_req
);
    logic             q_pop, q_clear;
    logic [CNT_W-1:0] occ;

    srq_fifo #(.DEPTH(DEPTH), .PC_W(PC_W), .SIG_W(SIG_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (disp_valid),
        .push_pc    (disp_pc),
        .push_sig   (disp_sig),
        .pop        (q_pop),
        .clear      (q_clear),
        .squash     (sq_valid),
        .squash_tag (sq_tag),
        .tail_tag   (disp_tag),
        .full       (disp_full),
        .head_valid (lk_valid),
        .head_pc    (lk_pc),
        .head_sig   (lk_sig),
        .count      (occ)
    );

    srq_check #(.PC_W(PC_W), .SIG_W(SIG_W)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_valid  (lk_valid),
        .head_pc     (lk_pc),
        .head_sig    (lk_sig),
        .cache_ready (lk_ready),
        .cache_hit   (lk_hit),
        .cache_sig   (lk_ref_sig),
        .pop         (q_pop),
        .clear       (q_clear),
        .wr_en       (wr_en),
        .flush_req   (flush_req),
        .restart_pc  (restart_pc),
        .fault_det   (fault_det),
        .recovered   (recovered),
        .abort_req   (abort_req)
    );

    assign wr_pc  = lk_pc;
    assign wr_sig = lk_sig;
endmodule

// File: rtl/srq_sva.sv
module srq_sva #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 16,
    parameter int SIG_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic [PC_W-1:0]  lk_pc,
    input logic [SIG_W-1:0] lk_sig,
    input logic             wr_en,
    input logic             disp_full,
    input logic             sq_valid,
    input logic             flush_req,
    input logic             fault_det,
    input logic             recovered,
    input logic             abort_req,
    input logic [CNT_W-1:0] occ
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_full && !sq_valid && !(lk_valid && lk_ready) |=> disp_full);

    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_ready |=> lk_valid && $stable(lk_pc) && $stable(lk_sig));

    p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !fault_det && !flush_req && !abort_req);

    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_det |-> flush_req && occ == '0);

    p_abort_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> !flush_req && occ == '0);

    p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_det, recovered, abort_req}));
endmodule

bind sig_commit_ctrl srq_sva #(.DEPTH(DEPTH), .PC_W(PC_W), .SIG_W(SIG_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .lk_pc     (lk_pc),
    .lk_sig    (lk_sig),
    .wr_en     (wr_en),
    .disp_full (disp_full),
    .sq_valid  (sq_valid),
    .flush_req (flush_req),
    .fault_det (fault_det),
    .recovered (recovered),
    .abort_req (abort_req),
    .occ       (occ)
);

// File: tb/sig_commit_ctrl_tb_top.sv
module sig_commit_ctrl_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [15:0] disp_pc = '0, disp_sig = '0;
    logic [2:0]  disp_tag;
    logic        disp_full;
    logic        sq_valid = 1'b0;
    logic [2:0]  sq_tag = '0;
    logic        lk_valid;
    logic [15:0] lk_pc, lk_sig;
    logic        lk_ready = 1'b0, lk_hit = 1'b0;
    logic [15:0] lk_ref_sig = '0;
    logic        wr_en;
    logic [15:0] wr_pc, wr_sig, restart_pc;
    logic        flush_req, fault_det, recovered, abort_req;

    always #4 clk = ~clk;

    sig_commit_ctrl #(.DEPTH(DEPTH), .PC_W(16), .SIG_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_pc(disp_pc), .disp_sig(disp_sig),
        .disp_tag(disp_tag), .disp_full(disp_full),
        .sq_valid(sq_valid), .sq_tag(sq_tag),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_sig(lk_sig),
        .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_ref_sig(lk_ref_sig),
        .wr_en(wr_en), .wr_pc(wr_pc), .wr_sig(wr_sig),
        .flush_req(flush_req), .restart_pc(restart_pc),
        .fault_det(fault_det), .recovered(recovered), .abort_req(abort_req)
    );

    // behavioural reference model
    typedef struct {
        logic [15:0] pc;
        logic [15:0] sig;
        int          tag;
    } ment_t;

    ment_t       mq[$];
    int          mtail = 0;
    bit          m_armed = 0;
    logic [15:0] m_armed_pc = '0;
    bit          e_flush = 0, e_fault = 0, e_rec = 0, e_abort = 0;
    logic [15:0] e_rpc = '0;

    int    n_chk = 0, n_fail = 0, n_cyc = 0;
    string phase = "R1 reset";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, phase, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog [%s] actual=%0d expected=<50000", phase, n_cyc);
            finish_up();
        end
    end

    task automatic compare_all();
        bit ev = (mq.size() > 0);
        chk("R2 lk_valid", 32'(lk_valid), 32'(ev));
        if (ev) begin
            chk("R2 lk_pc", 32'(lk_pc), 32'(mq[0].pc));
            chk("R2 lk_sig", 32'(lk_sig), 32'(mq[0].sig));
        end
        chk("R3 disp_full", 32'(disp_full), 32'(mq.size() == DEPTH));
        chk("R4 disp_tag", 32'(disp_tag), 32'(mtail));
        chk("R6 wr_en", 32'(wr_en), 32'(ev && lk_ready && !lk_hit));
        if (ev && lk_ready && !lk_hit) begin
            chk("R6 wr_pc", 32'(wr_pc), 32'(mq[0].pc));
            chk("R6 wr_sig", 32'(wr_sig), 32'(mq[0].sig));
        end
        chk("R8 flush_req", 32'(flush_req), 32'(e_flush));
        chk("R8 fault_det", 32'(fault_det), 32'(e_fault));
        if (e_flush) chk("R8 restart_pc", 32'(restart_pc), 32'(e_rpc));
        chk("R9 abort_req", 32'(abort_req), 32'(e_abort));
        chk("R10 recovered", 32'(recovered), 32'(e_rec));
    endtask

    task automatic model_edge();
        bit commit, retried, mism;
        int keep;
        int sz = mq.size();
        e_flush = 0; e_fault = 0; e_rec = 0; e_abort = 0;
        commit  = (sz > 0) && lk_ready;
        retried = commit && m_armed && (m_armed_pc == mq[0].pc);
        mism    = commit && lk_hit && (lk_ref_sig != mq[0].sig);
        if (mism) begin
            if (!retried) begin
                m_armed = 1; m_armed_pc = mq[0].pc;
                e_flush = 1; e_fault = 1; e_rpc = mq[0].pc;
            end else begin
                m_armed = 0; e_abort = 1;
            end
            mq.delete();
            mtail = 0;
        end else begin
            if (commit && retried) begin
                m_armed = 0;
                e_rec = lk_hit;
            end
            if (sq_valid) begin
                keep = 0;
                foreach (mq[i]) if (mq[i].tag == int'(sq_tag)) keep = i;
                while (mq.size() > keep + 1) void'(mq.pop_back());
                mtail = (int'(sq_tag) + 1) % DEPTH;
            end else if (disp_valid && sz < DEPTH) begin
                mq.push_back('{pc: disp_pc, sig: disp_sig, tag: mtail});
                mtail = (mtail + 1) % DEPTH;
            end
            if (commit) void'(mq.pop_front());
        end
    endtask

    task automatic cyc(input logic dv, input logic [15:0] dpc, input logic [15:0] dsig,
                       input logic sv, input int stag,
                       input logic rdy, input logic hit, input logic [15:0] rsig);
        disp_valid = dv; disp_pc = dpc; disp_sig = dsig;
        sq_valid = sv; sq_tag = 3'(stag);
        lk_ready = rdy; lk_hit = hit; lk_ref_sig = rsig;
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, 0, 0, 0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state observed before any stimulus
        #1;
        chk("R1 lk_valid", 32'(lk_valid), 0);
        chk("R1 disp_full", 32'(disp_full), 0);
        chk("R1 disp_tag", 32'(disp_tag), 0);
        chk("R1 pulses", 32'({wr_en, flush_req, fault_det, recovered, abort_req}), 0);
        @(negedge clk);

        phase = "R2 R5 dispatch with lookup stalled";
        cyc(1, 16'h0100, 16'h00A1, 0, 0, 0, 0, '0);
        cyc(1, 16'h0140, 16'h00B2, 0, 0, 0, 1, 16'hFFFF);
        cyc(1, 16'h0180, 16'h00C3, 0, 0, 0, 1, 16'hFFFF);
        idle(2);

        phase = "R6 miss writes";
        cyc(0, '0, '0, 0, 0, 1, 0, '0);
        phase = "R7 matching hit";
        cyc(0, '0, '0, 0, 0, 1, 1, 16'h00B2);
        phase = "R8 first mismatch";
        cyc(0, '0, '0, 0, 0, 1, 1, 16'h00FF);
        idle(2);

        phase = "R9 repeated mismatch";
        cyc(1, 16'h0180, 16'h00C3, 0, 0, 0, 0, '0);
        cyc(0, '0, '0, 0, 0, 1, 1, 16'h00FF);
        idle(2);

        phase = "R3 fill past depth";
        for (int i = 0; i < DEPTH + 2; i++)
            cyc(1, 16'(16'h0200 + i * 4), 16'(i + 1), 0, 0, 0, 0, '0);
        phase = "R4 squash with dispatch";
        cyc(1, 16'h0300, 16'h0033, 1, mq[2].tag, 0, 0, '0);
        cyc(1, 16'h0304, 16'h0034, 0, 0, 0, 0, '0);
        phase = "R6 drain by misses";
        for (int i = 0; i < 5; i++) cyc(0, '0, '0, 0, 0, 1, 0, '0);

        phase = "R10 fault then recovery";
        cyc(1, 16'h0400, 16'h0044, 0, 0, 0, 0, '0);
        cyc(0, '0, '0, 0, 0, 1, 1, 16'h0045);
        idle(1);
        phase = "R11 flag survives other commits";
        cyc(1, 16'h0500, 16'h0055, 0, 0, 0, 0, '0);
        cyc(1, 16'h0400, 16'h0044, 0, 0, 0, 0, '0);
        cyc(0, '0, '0, 0, 0, 1, 1, 16'h0055);
        cyc(0, '0, '0, 0, 0, 1, 1, 16'h0044);
        idle(1);
        phase = "R11 disarmed PC faults afresh";
        cyc(1, 16'h0400, 16'h0044, 0, 0, 0, 0, '0);
        cyc(0, '0, '0, 0, 0, 1, 1, 16'h0046);
        idle(1);

        phase = "R2 R4 R8 mixed traffic";
        for (int n = 0; n < 600; n++) begin
            logic dv = ($urandom % 3) != 0;
            logic [15:0] dpc = 16'(16'h0800 + ($urandom % 6) * 16);
            logic sv = 0;
            int st = 0;
            logic rdy = ($urandom % 3) != 0;
            logic hit = ($urandom % 4) != 0;
            logic [15:0] rsig = '0;
            if (mq.size() > 0 && ($urandom % 8) == 0) begin
                sv = 1;
                st = mq[$urandom % mq.size()].tag;
            end
            if (mq.size() > 0) rsig = (($urandom % 5) == 0) ? (mq[0].sig ^ 16'h1) : mq[0].sig;
            cyc(dv, dpc, dpc ^ 16'h5A5A, sv, st, rdy, hit, rsig);
        end
        idle(2);
        finish_up();
    end
endmodule